// File: doc/BRIEF.md
# Receive Bit-Rate Measurement Unit

This block works out the speed of a serial line from one sync character, 0x55, sent by the far end. Software arms the unit with a one-cycle `arm_i` pulse. While the unit is armed, the transmit side must stay quiet, so `tx_block_o` is held high. The receive line first passes through a two-stage synchronizer. The first falling edge after arming, which is the start bit, clears a measurement counter. That counter advances once every 128 peripheral clocks (a divide-by-8 stage times the 16x oversampling ratio).

The character 0x55 gives five falling edges, eight bit times apart from first to last. On the fifth edge the unit does four things in the same cycle:
- it loads the count into the divisor output;
- it pulses the load strobe;
- it pulses the receive interrupt;
- it disarms itself.

Because the span is eight bits and the counter runs at one 128th of the clock, the count equals bit time divided by 16. That is the divisor a 16x-oversampling baud generator needs. If the counter would pass its maximum before the fifth edge, it holds at the maximum and a range-error flag is raised. The flag stays set until the next arm.

Top module: `abd_unit`

## Requirements
- R1: After synchronous reset, `enable_o`, `tx_block_o`, `range_err_o`, `rx_irq_o` and `div_load_o` are 0, and `divisor_o` is 0.
- R2: An `arm_i` pulse while disarmed sets `enable_o` in the next cycle. An `arm_i` pulse while already armed has no effect, and the running measurement completes normally with one interrupt.
- R3: Falling edges on `rx_i` while disarmed have no effect: no interrupt, no load strobe, and `divisor_o` is unchanged.
- R4: The measurement runs from the first falling edge after arming to the fifth. The counter advances once per 128 clocks, and the loaded divisor equals floor(8·B/128) for a bit time of B clocks, where 0x55 is sent least significant bit first between a low start bit and a high stop bit.
- R5: `divisor_o` changes only in a cycle where `div_load_o` is high. Each completed measurement replaces the previous divisor.
- R6: On completion, `rx_irq_o` and `div_load_o` are high together for exactly one cycle, and `enable_o` is 0 in that same cycle.
- R7: `tx_block_o` is high for the whole armed period, from the cycle after arming until completion, and is low once disarmed.
- R8: When the count would exceed 2^CNT_W−1, it holds at that value, the loaded divisor is 2^CNT_W−1, and `range_err_o` is set. A count that lands exactly on the maximum sets no error. `range_err_o` clears on the next arm.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Synchronous active-low reset |
| arm_i | input | 1 | One-cycle pulse that arms detection |
| rx_i | input | 1 | Asynchronous serial receive line, idle high |
| enable_o | output | 1 | Detection armed; clears itself on completion |
| tx_block_o | output | 1 | Transmitter inhibit while armed |
| divisor_o | output | CNT_W | Measured baud divisor |
| div_load_o | output | 1 | One-cycle strobe when `divisor_o` is written |
| rx_irq_o | output | 1 | One-cycle receive interrupt at completion |
| range_err_o | output | 1 | Counter saturated during the last measurement |

## Verification
The bench sends sync characters at bit times that divide evenly by 16 and at bit times that do not. This exposes a counter that drops or adds the prescaler tick landing on the final edge; such a design would load a divisor one off. Characters sent while disarmed, and arm pulses sent mid-measurement, catch a design that counts unarmed edges or restarts on a second arm. Either fault shows up as a stray interrupt or a wrong divisor. A narrow-counter instance is driven to exactly the maximum count and one tick past it. A design that wrapped instead of saturating would load a small divisor, and one that flagged too early would report an error on the exact fit.

// File: rtl/abd_pkg.sv
// Shared types for the bit-rate measurement unit.
// Assumes: nothing beyond standard SystemVerilog.
package abd_pkg;
    typedef enum logic [1:0] {
        ABD_OFF  = 2'd0,   // disarmed
        ABD_WAIT = 2'd1,   // armed, waiting for start-bit edge
        ABD_MEAS = 2'd2    // counting between edges
    } abd_state_e;
endpackage

// File: rtl/abd_rx_edge.sv
// Synchronizes the asynchronous receive line and flags high-to-low transitions.
// Assumes: line idles high; SYNC_STAGES >= 2.
module abd_rx_edge #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rx_i,
    output logic fall_o
);
    logic [SYNC_STAGES-1:0] sync_q;
    logic                   prev_q;

    // Shift the raw line through the synchronizer chain, reset to idle-high.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_q <= '1;
            prev_q <= 1'b1;
        end else begin
            sync_q <= {sync_q[SYNC_STAGES-2:0], rx_i};
            prev_q <= sync_q[SYNC_STAGES-1];
        end
    end

    assign fall_o = prev_q & ~sync_q[SYNC_STAGES-1];

    // A falling edge needs the line high again before another can be seen.
    p_fall_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
        fall_o |=> !fall_o);
endmodule

// File: rtl/abd_prescaler.sv
// Divides the peripheral clock by DIV, giving a one-cycle tick while running.
// Assumes: clear_i and run_i are not high together; DIV >= 2.
module abd_prescaler #(
    parameter int DIV = 128
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear_i,
    input  logic run_i,
    output logic tick_o
);
    localparam int PW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [PW-1:0] LAST = PW'(DIV - 1);

    logic [PW-1:0] cnt_q;

    assign tick_o = run_i && (cnt_q == LAST);

    // Count clocks modulo DIV; restart from zero on clear.
    always_ff @(posedge clk) begin
        if (!rst_n || clear_i) begin
            cnt_q <= '0;
        end else if (run_i) begin
            cnt_q <= tick_o ? '0 : cnt_q + 1'b1;
        end
    end

    generate
        if (DIV > 1) begin : g_spacing_chk
            p_tick_spacing_r4: assert property (@(posedge clk) disable iff (!rst_n)
                tick_o |=> !tick_o);
        end
    endgenerate
endmodule

// File: rtl/abd_sat_counter.sv
// Saturating up-counter; next_o shows the value including this cycle's increment.
// Assumes: clear_i has priority over inc_i.
module abd_sat_counter #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clear_i,
    input  logic         inc_i,
    output logic [W-1:0] value_o,
    output logic [W-1:0] next_o,
    output logic         sat_hit_o
);
    localparam logic [W-1:0] MAXV = '1;

    logic [W-1:0] cnt_q;

    assign sat_hit_o = inc_i && (cnt_q == MAXV);
    assign next_o    = (inc_i && !sat_hit_o) ? cnt_q + 1'b1 : cnt_q;
    assign value_o   = cnt_q;

    // Hold the running count, clearing on request.
    always_ff @(posedge clk) begin
        if (!rst_n || clear_i) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= next_o;
        end
    end

    p_saturate_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (sat_hit_o && !clear_i) |=> (cnt_q == MAXV));
endmodule

// File: rtl/abd_unit.sv
// Bit-rate measurement unit: arms on request, times five falling edges of a
// 0x55 sync character with a clock/(PRE_DIV*OVERSAMPLE) counter, loads the
// divisor, disarms itself and raises a receive interrupt.
// Assumes: arm_i is a single-cycle pulse; the character is 0x55 with one start bit.
module abd_unit #(
    parameter int CNT_W       = 16,
    parameter int PRE_DIV     = 8,
    parameter int OVERSAMPLE  = 16,
    parameter int SYNC_STAGES = 2,
    parameter int EDGES       = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             arm_i,
    input  logic             rx_i,
    output logic             enable_o,
    output logic             tx_block_o,
    output logic [CNT_W-1:0] divisor_o,
    output logic             div_load_o,
    output logic             rx_irq_o,
    output logic             range_err_o
);
    import abd_pkg::*;

    localparam int DIV = PRE_DIV * OVERSAMPLE;
    localparam int EW  = $clog2(EDGES + 1);
    localparam logic [EW-1:0] LAST_EDGE = EW'(EDGES - 1);

    abd_state_e       state_q;
    logic [EW-1:0]    edges_q;
    logic             fall;
    logic             tick;
    logic             start_edge;
    logic             measuring;
    logic [CNT_W-1:0] cnt_val;
    logic [CNT_W-1:0] cnt_next;
    logic             sat_hit;

    assign start_edge = (state_q == ABD_WAIT) && fall;
    assign measuring  = (state_q == ABD_MEAS);

    abd_rx_edge #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .rx_i   (rx_i),
        .fall_o (fall)
    );

    abd_prescaler #(.DIV(DIV)) u_presc (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear_i (start_edge),
        .run_i   (measuring),
        .tick_o  (tick)
    );

    abd_sat_counter #(.W(CNT_W)) u_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear_i   (start_edge),
        .inc_i     (measuring && tick),
        .value_o   (cnt_val),
        .next_o    (cnt_next),
        .sat_hit_o (sat_hit)
    );

    // Sequence arming, edge counting, divisor load and auto-clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q     <= ABD_OFF;
            edges_q     <= '0;
            divisor_o   <= '0;
            div_load_o  <= 1'b0;
            rx_irq_o    <= 1'b0;
            range_err_o <= 1'b0;
        end else begin
            div_load_o <= 1'b0;
            rx_irq_o   <= 1'b0;
            case (state_q)
                ABD_OFF: begin
                    if (arm_i) begin
                        state_q     <= ABD_WAIT;
                        range_err_o <= 1'b0;
                    end
                end
                ABD_WAIT: begin
                    if (fall) begin
                        state_q <= ABD_MEAS;
                        edges_q <= EW'(1);
                    end
                end
                ABD_MEAS: begin
                    if (sat_hit) begin
                        range_err_o <= 1'b1;
                    end
                    if (fall) begin
                        if (edges_q == LAST_EDGE) begin
                            divisor_o  <= cnt_next;
                            div_load_o <= 1'b1;
                            rx_irq_o   <= 1'b1;
                            state_q    <= ABD_OFF;
                            edges_q    <= '0;
                        end else begin
                            edges_q <= edges_q + 1'b1;
                        end
                    end
                end
                default: state_q <= ABD_OFF;
            endcase
        end
    end

    assign enable_o   = (state_q != ABD_OFF);
    assign tx_block_o = (state_q != ABD_OFF);

    p_irq_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
        rx_irq_o |=> !rx_irq_o);
    p_autoclear_r6: assert property (@(posedge clk) disable iff (!rst_n)
        rx_irq_o |-> (!enable_o && div_load_o));
    p_div_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (divisor_o != $past(divisor_o)) |-> div_load_o);
    p_arm_rise_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(enable_o) |-> $past(arm_i));
    p_err_at_max_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (div_load_o && range_err_o) |-> (divisor_o == '1));
    p_count_unused_r4: assert property (@(posedge clk) disable iff (!rst_n)
        start_edge |=> (cnt_val == '0));
endmodule

// File: tb/tb_abd_unit.sv
module tb_abd_unit;
    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 5;
    localparam int BIT_CLKS [NVEC] = '{16, 48, 100, 160, 33};

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic arm_a = 1'b0, rx_a = 1'b1;
    logic arm_b = 1'b0, rx_b = 1'b1;

    logic        en_a, txb_a, ld_a, irq_a, err_a;
    logic [15:0] div_a;
    logic        en_b, txb_b, ld_b, irq_b, err_b;
    logic [3:0]  div_b;

    int checks = 0;
    int fails = 0;
    int irq_cnt_a = 0, irq_cnt_b = 0, mismatch = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    abd_unit dut (
        .clk(clk), .rst_n(rst_n), .arm_i(arm_a), .rx_i(rx_a),
        .enable_o(en_a), .tx_block_o(txb_a), .divisor_o(div_a),
        .div_load_o(ld_a), .rx_irq_o(irq_a), .range_err_o(err_a));

    abd_unit #(.CNT_W(4)) dut_sat (
        .clk(clk), .rst_n(rst_n), .arm_i(arm_b), .rx_i(rx_b),
        .enable_o(en_b), .tx_block_o(txb_b), .divisor_o(div_b),
        .div_load_o(ld_b), .rx_irq_o(irq_b), .range_err_o(err_b));

    // Count interrupts and check that strobe and interrupt coincide, with enable low.
    always @(negedge clk) begin
        if (rst_n) begin
            if (irq_a) irq_cnt_a++;
            if (irq_b) irq_cnt_b++;
            if (irq_a != ld_a || irq_b != ld_b) mismatch++;
            if (irq_a && en_a) mismatch++;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wclk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse_arm(input bit which);
        if (which) arm_b = 1'b1; else arm_a = 1'b1;
        wclk(1);
        arm_a = 1'b0; arm_b = 1'b0;
    endtask

    // Send 0x55 LSB first with one start and one stop bit, b clocks per bit.
    task automatic send_sync(input bit which, input int b);
        logic [9:0] frame;
        frame = {1'b1, 8'h55, 1'b0};
        for (int i = 0; i < 10; i++) begin
            if (which) rx_b = frame[i]; else rx_a = frame[i];
            wclk(b);
        end
        wclk(8);
    endtask

    task automatic report;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        checks++; fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        report();
    end

    initial begin
        wclk(4);
        // R1 reset state
        chk("R1 enable", en_a, 0);
        chk("R1 tx_block", txb_a, 0);
        chk("R1 divisor", div_a, 0);
        chk("R1 irq/load", {irq_a, ld_a, err_a}, 0);
        rst_n = 1'b1;
        wclk(2);

        // R3 unarmed character is ignored
        send_sync(0, 48);
        chk("R3 irq count", irq_cnt_a, 0);
        chk("R3 divisor", div_a, 0);
        chk("R3 enable", en_a, 0);

        // R4/R5 vector table: each measurement replaces the divisor
        for (int v = 0; v < NVEC; v++) begin
            pulse_arm(0);
            chk("R2 enable after arm", en_a, 1);
            chk("R7 tx_block while armed", txb_a, 1);
            send_sync(0, BIT_CLKS[v]);
            chk("R4 divisor", div_a, (8 * BIT_CLKS[v]) / 128);
            chk("R5 irq count", irq_cnt_a, v + 1);
            chk("R6 enable auto-cleared", en_a, 0);
            chk("R7 tx_block released", txb_a, 0);
        end

        // R2 re-arm mid-measurement has no effect
        pulse_arm(0);
        fork
            send_sync(0, 64);
            begin
                wclk(64 * 3);
                pulse_arm(0);
                chk("R7 tx_block mid frame", txb_a, 1);
            end
        join
        chk("R2 divisor with mid arm", div_a, 4);
        chk("R2 single irq", irq_cnt_a, NVEC + 1);

        // R8 exact fit on 4-bit counter: no error
        pulse_arm(1);
        send_sync(1, 240);
        chk("R8 exact max divisor", div_b, 15);
        chk("R8 exact max no error", err_b, 0);
        // R8 one tick past max: saturates and flags
        pulse_arm(1);
        send_sync(1, 256);
        chk("R8 saturated divisor", div_b, 15);
        chk("R8 error set", err_b, 1);
        pulse_arm(1);
        chk("R8 error cleared on arm", err_b, 0);
        send_sync(1, 32);
        chk("R8 after clear divisor", div_b, 2);
        chk("R6 irq count sat", irq_cnt_b, 3);

        chk("R6 strobe/irq/enable coincidence", mismatch, 0);
        report();
    end
endmodule